// File: doc/BRIEF.md
# Dual-Output Set/Reset Stage with Output Swap

This block drives two PWM output levels from a shared bus of timing event pulses: a period event, a set of compare events, and a few other events. Each output has its own pair of event-select masks. One mask lists the events that drive the output high, and the other lists the events that drive it low. A single swap request bit can exchange which mask pair drives which output. The exchange happens ahead of the output flip-flops. It passes through a preload copy and reaches the active copy only on an update strobe, so the mapping never changes in the middle of a cycle.

The block also checks the compare values it is given. A nonzero compare value below three high-resolution clock periods is flagged. The threshold is 0x60 shifted right by the prescaler setting. A zero compare value is also flagged, except in one configuration that is known to give a clean skipped pulse. Because a reset event beats a set event in the same cycle, software can also obtain a zero-duty cycle another way: it selects the same legal compare event for both set and reset.

Top module: `pwm_setreset_pair`

## Requirements
- R1: The event bus index is fixed: bit 0 is the period event, bits 1..NUM_CMP are compare 1..NUM_CMP, and higher bits are other events. An output goes high on the clock edge after a cycle in which one of its selected set events pulses and none of its selected reset events pulses.
- R2: An output goes low on the clock edge after a cycle in which one of its selected reset events pulses.
- R3: An output keeps its level when none of its selected set or reset events pulses, including when only unselected event bits pulse.
- R4: If a set event and a reset event of the same output pulse in the same cycle, the output is low afterwards. This holds even when both masks select the same compare event.
- R5: While the active swap state is 1, the output-1 mask pair drives output 2 and the output-2 mask pair drives output 1. While it is 0, each pair drives its own output.
- R6: With preload enabled, the swap request is captured into a preload copy on every clock edge. The active swap state takes the preload copy only on an edge where the update strobe is high, so a new request does not change the mapping before the update.
- R7: With preload disabled, the preload copy ignores the swap request, so an update does not change the mapping. While the request differs from the preload copy, the error flag is high from the next edge on.
- R8: A nonzero compare value below 0x60 >> prescaler raises the error flag one edge later. A value equal to or above that threshold does not. For example, the thresholds are 0x60, 0x30 and 0x18 for prescaler settings 0, 1 and 2.
- R9: A zero compare value raises the error flag except for compare 1 and compare 3 when all of the following hold. First, both of those compares are zero. Second, both outputs' set masks are exactly the period bit (0x01). Third, both reset masks are nonzero and select only compare 1 (bit 1) and/or compare 3 (bit 3). Fourth, each of those compares that is selected is marked private: cmp_local_i bit 0 for compare 1, bit 1 for compare 3.
- R10: During reset both outputs are low, the error flag is low, and both swap copies are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVW | Event pulses: bit 0 period, bits 1..NUM_CMP compares, then other events |
| set1_mask_i | input | EVW | Set-event selection for output 1 |
| rst1_mask_i | input | EVW | Reset-event selection for output 1 |
| set2_mask_i | input | EVW | Set-event selection for output 2 |
| rst2_mask_i | input | EVW | Reset-event selection for output 2 |
| swap_i | input | 1 | Swap request, written into the preload copy |
| preload_en_i | input | 1 | Enables capture of the swap request |
| update_i | input | 1 | Update strobe: moves the preload copy into the active copy |
| cmp_vals_i | input | NUM_CMP*CMP_W | Compare values; compare 1 in the lowest CMP_W bits |
| cmp_local_i | input | 2 | Bit 0: compare 1 is private to this timer; bit 1: same for compare 3 |
| psc_i | input | PSC_W | Prescaler setting that scales the compare floor |
| out1_o | output | 1 | Output 1 level |
| out2_o | output | 1 | Output 2 level |
| cfg_err_o | output | 1 | Configuration error flag |

## Verification
A stepped table of event patterns runs against fixed masks. The patterns are lone set events, lone reset events, both of them together, and only unselected bits. Together they separate the set, clear, hold and reset-priority paths of each output. Swap sequences drive events before and after the update strobe, with preload on and off. These sequences separate a correct crossbar from one that is applied too early, one that never switches, or one that ignores preload. Compare values are tried just below and exactly at the floor for three prescaler settings. A zero-compare setup is then broken one condition at a time, which shows that each condition of the skipped-pulse exception is enforced on its own.

// File: rtl/pwm_sr_pkg.sv
package pwm_sr_pkg;

   // mapping of mask pairs onto the two outputs
   typedef enum logic {
      MAP_DIRECT  = 1'b0,
      MAP_SWAPPED = 1'b1
   } map_e;

   // fixed positions on the event bus
   localparam int unsigned EVT_PERIOD_BIT = 0;
   localparam int unsigned EVT_CMP_FIRST  = 1;
   localparam int unsigned EVT_CMP1_BIT   = EVT_CMP_FIRST + 0;
   localparam int unsigned EVT_CMP3_BIT   = EVT_CMP_FIRST + 2;

   // number of driven outputs
   localparam int unsigned N_OUT = 2;

endpackage

// File: rtl/sr_swap_cfg.sv
module sr_swap_cfg
   import pwm_sr_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic swap_req_i,
   input  logic preload_en_i,
   input  logic update_i,
   output map_e map_pre_o,
   output map_e map_act_o
);

   map_e pre_q;
   map_e act_q;
   map_e req;

   assign req = swap_req_i ? MAP_SWAPPED : MAP_DIRECT;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= MAP_DIRECT;
         act_q <= MAP_DIRECT;
      end else begin
         if (preload_en_i) begin
            pre_q <= req;
         end
         if (update_i) begin
            act_q <= pre_q;
         end
      end
   end

   assign map_pre_o = pre_q;
   assign map_act_o = act_q;

endmodule

// File: rtl/sr_out_cell.sv
module sr_out_cell #(
   parameter int unsigned EVW = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [EVW-1:0] evt_i,
   input  logic [EVW-1:0] set_sel_i,
   input  logic [EVW-1:0] clr_sel_i,
   output logic           q_o
);

   logic set_hit;
   logic clr_hit;
   logic q_q;
   logic q_d;

   assign set_hit = |(evt_i & set_sel_i);
   assign clr_hit = |(evt_i & clr_sel_i);

   // clearing dominates setting
   always_comb begin
      q_d = q_q;
      if (clr_hit) begin
         q_d = 1'b0;
      end else if (set_hit) begin
         q_d = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_q <= 1'b0;
      end else begin
         q_q <= q_d;
      end
   end

   assign q_o = q_q;

endmodule

// File: rtl/cmp_floor_chk.sv
module cmp_floor_chk #(
   parameter int unsigned CMP_W    = 16,
   parameter int unsigned PSC_W    = 3,
   parameter int unsigned BASE_MIN = 96
) (
   input  logic [CMP_W-1:0] value_i,
   input  logic [PSC_W-1:0] psc_i,
   input  logic             zero_ok_i,
   output logic             bad_o
);

   logic [CMP_W-1:0] floor_v;
   logic             is_zero;
   logic             too_small;

   assign floor_v   = CMP_W'(BASE_MIN) >> psc_i;
   assign is_zero   = (value_i == '0);
   assign too_small = !is_zero && (value_i < floor_v);
   assign bad_o     = too_small || (is_zero && !zero_ok_i);

endmodule

// File: rtl/null_duty_qual.sv
module null_duty_qual
   import pwm_sr_pkg::*;
#(
   parameter int unsigned EVW = 8
) (
   input  logic [EVW-1:0] set1_i,
   input  logic [EVW-1:0] rst1_i,
   input  logic [EVW-1:0] set2_i,
   input  logic [EVW-1:0] rst2_i,
   input  logic           cmp1_zero_i,
   input  logic           cmp3_zero_i,
   input  logic [1:0]     local_i,
   output logic           ok_o
);

   localparam logic [EVW-1:0] PERIOD_ONLY = EVW'(1) << EVT_PERIOD_BIT;
   localparam logic [EVW-1:0] RST_ALLOWED = (EVW'(1) << EVT_CMP1_BIT) |
                                            (EVW'(1) << EVT_CMP3_BIT);

   logic [EVW-1:0] set_m [N_OUT];
   logic [EVW-1:0] rst_m [N_OUT];
   logic [N_OUT-1:0] out_ok;

   assign set_m[0] = set1_i;
   assign set_m[1] = set2_i;
   assign rst_m[0] = rst1_i;
   assign rst_m[1] = rst2_i;

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      logic set_fit;
      logic rst_fit;
      logic loc_fit;
      assign set_fit = (set_m[k] == PERIOD_ONLY);
      assign rst_fit = (rst_m[k] != '0) && ((rst_m[k] & ~RST_ALLOWED) == '0);
      assign loc_fit = (!rst_m[k][EVT_CMP1_BIT] || local_i[0]) &&
                       (!rst_m[k][EVT_CMP3_BIT] || local_i[1]);
      assign out_ok[k] = set_fit && rst_fit && loc_fit;
   end

   assign ok_o = cmp1_zero_i && cmp3_zero_i && (&out_ok);

endmodule

// File: rtl/pwm_setreset_pair.sv
module pwm_setreset_pair
   import pwm_sr_pkg::*;
#(
   parameter int unsigned NUM_CMP  = 4,
   parameter int unsigned NUM_EXT  = 3,
   parameter int unsigned CMP_W    = 16,
   parameter int unsigned PSC_W    = 3,
   parameter int unsigned BASE_MIN = 96,
   localparam int unsigned EVW     = 1 + NUM_CMP + NUM_EXT,
   localparam int unsigned CVW     = NUM_CMP * CMP_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [EVW-1:0]   evt_i,
   input  logic [EVW-1:0]   set1_mask_i,
   input  logic [EVW-1:0]   rst1_mask_i,
   input  logic [EVW-1:0]   set2_mask_i,
   input  logic [EVW-1:0]   rst2_mask_i,
   input  logic             swap_i,
   input  logic             preload_en_i,
   input  logic             update_i,
   input  logic [CVW-1:0]   cmp_vals_i,
   input  logic [1:0]       cmp_local_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             out1_o,
   output logic             out2_o,
   output logic             cfg_err_o
);

   // elaboration-time parameter checks
   if (NUM_CMP < 3) begin : g_bad_ncmp
      $error("pwm_setreset_pair: NUM_CMP must be at least 3");
   end
   if (PSC_W < 1) begin : g_bad_psc
      $error("pwm_setreset_pair: PSC_W must be at least 1");
   end
   if (BASE_MIN >= (1 << CMP_W)) begin : g_bad_min
      $error("pwm_setreset_pair: BASE_MIN does not fit CMP_W");
   end

   // swap preload / active copies
   map_e map_pre;
   map_e map_act;
   logic swap_viol;

   sr_swap_cfg u_cfg (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .swap_req_i   (swap_i),
      .preload_en_i (preload_en_i),
      .update_i     (update_i),
      .map_pre_o    (map_pre),
      .map_act_o    (map_act)
   );

   // a request that the preload copy refuses to take
   assign swap_viol = !preload_en_i && (swap_i != (map_pre == MAP_SWAPPED));

   // crossbar ahead of the output flops
   logic [EVW-1:0] set_sel [N_OUT];
   logic [EVW-1:0] clr_sel [N_OUT];
   logic [N_OUT-1:0] out_q;

   always_comb begin
      if (map_act == MAP_SWAPPED) begin
         set_sel[0] = set2_mask_i;
         clr_sel[0] = rst2_mask_i;
         set_sel[1] = set1_mask_i;
         clr_sel[1] = rst1_mask_i;
      end else begin
         set_sel[0] = set1_mask_i;
         clr_sel[0] = rst1_mask_i;
         set_sel[1] = set2_mask_i;
         clr_sel[1] = rst2_mask_i;
      end
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_cell
      sr_out_cell #(
         .EVW (EVW)
      ) u_cell (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .evt_i     (evt_i),
         .set_sel_i (set_sel[k]),
         .clr_sel_i (clr_sel[k]),
         .q_o       (out_q[k])
      );
   end

   assign out1_o = out_q[0];
   assign out2_o = out_q[1];

   // compare value checks
   logic [CMP_W-1:0]   cmp_v [NUM_CMP];
   logic [NUM_CMP-1:0] zero_ok;
   logic [NUM_CMP-1:0] cmp_bad;
   logic               null_ok;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      assign cmp_v[i] = cmp_vals_i[i*CMP_W +: CMP_W];
   end

   null_duty_qual #(
      .EVW (EVW)
   ) u_null (
      .set1_i      (set1_mask_i),
      .rst1_i      (rst1_mask_i),
      .set2_i      (set2_mask_i),
      .rst2_i      (rst2_mask_i),
      .cmp1_zero_i (cmp_v[0] == '0),
      .cmp3_zero_i (cmp_v[2] == '0),
      .local_i     (cmp_local_i),
      .ok_o        (null_ok)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_floor
      if (i == 0 || i == 2) begin : g_zero_exempt
         assign zero_ok[i] = null_ok;
      end else begin : g_zero_banned
         assign zero_ok[i] = 1'b0;
      end

      cmp_floor_chk #(
         .CMP_W    (CMP_W),
         .PSC_W    (PSC_W),
         .BASE_MIN (BASE_MIN)
      ) u_floor (
         .value_i   (cmp_v[i]),
         .psc_i     (psc_i),
         .zero_ok_i (zero_ok[i]),
         .bad_o     (cmp_bad[i])
      );
   end

   // registered error flag
   logic err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
      end else begin
         err_q <= (|cmp_bad) || swap_viol;
      end
   end

   assign cfg_err_o = err_q;

endmodule

// File: rtl/sr_pair_chk.sv
module sr_pair_chk #(
   parameter int unsigned EVW = 8
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic [EVW-1:0] evt_i,
   input logic [EVW-1:0] set1_mask_i,
   input logic [EVW-1:0] rst1_mask_i,
   input logic [EVW-1:0] set2_mask_i,
   input logic [EVW-1:0] rst2_mask_i,
   input logic           swap_i,
   input logic           preload_en_i,
   input logic           update_i,
   input logic           map_pre_i,
   input logic           map_act_i,
   input logic           out1_o,
   input logic           out2_o,
   input logic           cfg_err_o
);

   logic s1, c1, s2, c2;

   assign s1 = |(evt_i & (map_act_i ? set2_mask_i : set1_mask_i));
   assign c1 = |(evt_i & (map_act_i ? rst2_mask_i : rst1_mask_i));
   assign s2 = |(evt_i & (map_act_i ? set1_mask_i : set2_mask_i));
   assign c2 = |(evt_i & (map_act_i ? rst1_mask_i : rst2_mask_i));

   a_r10_reset_low: assert property (@(posedge clk_i) !rst_ni |-> (!out1_o && !out2_o && !cfg_err_o));

   a_r1_set_out1: assert property (@(posedge clk_i) disable iff (!rst_ni) (s1 && !c1) |=> out1_o);
   a_r1_set_out2: assert property (@(posedge clk_i) disable iff (!rst_ni) (s2 && !c2) |=> out2_o);

   // R4: a clear pulse wins over a simultaneous set pulse
   a_r4_clear_out1: assert property (@(posedge clk_i) disable iff (!rst_ni) c1 |=> !out1_o);
   a_r4_clear_out2: assert property (@(posedge clk_i) disable iff (!rst_ni) c2 |=> !out2_o);

   a_r3_hold_out1: assert property (@(posedge clk_i) disable iff (!rst_ni) (!s1 && !c1) |=> $stable(out1_o));
   a_r3_hold_out2: assert property (@(posedge clk_i) disable iff (!rst_ni) (!s2 && !c2) |=> $stable(out2_o));

   a_r6_act_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni) !update_i |=> $stable(map_act_i));

   a_r7_pre_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni) !preload_en_i |=> $stable(map_pre_i));

   a_r7_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!preload_en_i && (swap_i != map_pre_i)) |=> cfg_err_o);

endmodule

bind pwm_setreset_pair sr_pair_chk #(
   .EVW (EVW)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .evt_i        (evt_i),
   .set1_mask_i  (set1_mask_i),
   .rst1_mask_i  (rst1_mask_i),
   .set2_mask_i  (set2_mask_i),
   .rst2_mask_i  (rst2_mask_i),
   .swap_i       (swap_i),
   .preload_en_i (preload_en_i),
   .update_i     (update_i),
   .map_pre_i    (map_pre),
   .map_act_i    (map_act),
   .out1_o       (out1_o),
   .out2_o       (out2_o),
   .cfg_err_o    (cfg_err_o)
);

// File: tb/tb_pwm_setreset_pair.sv
`timescale 1ns/1ps
module tb_pwm_setreset_pair;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic [7:0]  evt_i;
   logic [7:0]  set1_mask_i, rst1_mask_i, set2_mask_i, rst2_mask_i;
   logic        swap_i, preload_en_i, update_i;
   logic [63:0] cmp_vals_i;
   logic [1:0]  cmp_local_i;
   logic [2:0]  psc_i;
   logic        out1_o, out2_o, cfg_err_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk_i = ~clk_i;

   pwm_setreset_pair dut (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .evt_i        (evt_i),
      .set1_mask_i  (set1_mask_i),
      .rst1_mask_i  (rst1_mask_i),
      .set2_mask_i  (set2_mask_i),
      .rst2_mask_i  (rst2_mask_i),
      .swap_i       (swap_i),
      .preload_en_i (preload_en_i),
      .update_i     (update_i),
      .cmp_vals_i   (cmp_vals_i),
      .cmp_local_i  (cmp_local_i),
      .psc_i        (psc_i),
      .out1_o       (out1_o),
      .out2_o       (out2_o),
      .cfg_err_o    (cfg_err_o)
   );

   typedef struct packed {
      logic [7:0] evt;
      logic       e1;
      logic       e2;
      logic [3:0] req;
   } vec_t;

   // masks: set1=period, rst1=cmp1, set2=cmp2, rst2=cmp3
   localparam vec_t VEC [10] = '{
      '{8'h01, 1'b1, 1'b0, 4'd1},  // R1 period sets out1
      '{8'h00, 1'b1, 1'b0, 4'd3},  // R3 hold
      '{8'h04, 1'b1, 1'b1, 4'd1},  // R1 cmp2 sets out2
      '{8'h02, 1'b0, 1'b1, 4'd2},  // R2 cmp1 clears out1
      '{8'h08, 1'b0, 1'b0, 4'd2},  // R2 cmp3 clears out2
      '{8'h05, 1'b1, 1'b1, 4'd1},  // R1 both set
      '{8'h0F, 1'b0, 1'b0, 4'd4},  // R4 set+reset together
      '{8'hF0, 1'b0, 1'b0, 4'd3},  // R3 unselected bits only
      '{8'h01, 1'b1, 1'b0, 4'd1},  // R1
      '{8'h03, 1'b0, 1'b0, 4'd4}   // R4
   };

   task automatic chk(input logic act, input logic exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] ev);
      evt_i = ev;
      @(negedge clk_i);
      evt_i = '0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         n_fail++;
         $display("FAIL R10 watchdog expired: got running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_ni       = 1'b0;
      evt_i        = '0;
      set1_mask_i  = 8'h01;
      rst1_mask_i  = 8'h02;
      set2_mask_i  = 8'h04;
      rst2_mask_i  = 8'h08;
      swap_i       = 1'b0;
      preload_en_i = 1'b1;
      update_i     = 1'b0;
      cmp_vals_i   = {4{16'h0100}};
      cmp_local_i  = 2'b11;
      psc_i        = '0;
      repeat (3) @(negedge clk_i);
      chk(out1_o, 1'b0, "R10 out1 in reset");
      chk(out2_o, 1'b0, "R10 out2 in reset");
      chk(cfg_err_o, 1'b0, "R10 err in reset");
      rst_ni = 1'b1;
      @(negedge clk_i);

      for (int i = 0; i < 10; i++) begin
         apply(VEC[i].evt);
         chk(out1_o, VEC[i].e1, $sformatf("R%0d vec %0d out1", VEC[i].req, i));
         chk(out2_o, VEC[i].e2, $sformatf("R%0d vec %0d out2", VEC[i].req, i));
         chk(cfg_err_o, 1'b0, $sformatf("R8 vec %0d err", i));
      end

      // R6: request captured but not active before update
      swap_i = 1'b1;
      apply(8'h00);
      apply(8'h01);
      chk(out1_o, 1'b1, "R6 no swap before update out1");
      chk(out2_o, 1'b0, "R6 no swap before update out2");
      apply(8'h02);
      update_i = 1'b1;
      apply(8'h00);
      update_i = 1'b0;
      // R5: swapped mapping
      apply(8'h01);
      chk(out1_o, 1'b0, "R5 swapped out1");
      chk(out2_o, 1'b1, "R5 swapped out2");
      apply(8'h04);
      chk(out1_o, 1'b1, "R5 swapped set2 drives out1");
      apply(8'h0A);
      chk(out1_o, 1'b0, "R5 rst2 clears out1");
      chk(out2_o, 1'b0, "R5 rst1 clears out2");

      // R7: preload off, request ignored
      preload_en_i = 1'b0;
      swap_i       = 1'b0;
      apply(8'h00);
      chk(cfg_err_o, 1'b1, "R7 err on ignored swap");
      update_i = 1'b1;
      apply(8'h00);
      update_i = 1'b0;
      apply(8'h01);
      chk(out1_o, 1'b0, "R7 mapping kept out1");
      chk(out2_o, 1'b1, "R7 mapping kept out2");
      chk(cfg_err_o, 1'b1, "R7 err held");
      apply(8'h02);
      swap_i = 1'b1;
      apply(8'h00);
      chk(cfg_err_o, 1'b0, "R7 err clears when request matches");

      // R6: swap back with preload on
      preload_en_i = 1'b1;
      swap_i       = 1'b0;
      apply(8'h00);
      update_i = 1'b1;
      apply(8'h00);
      update_i = 1'b0;
      apply(8'h01);
      chk(out1_o, 1'b1, "R6 direct again out1");
      chk(out2_o, 1'b0, "R6 direct again out2");
      apply(8'h02);

      // R4: same compare selected for set and reset
      set1_mask_i = 8'h04;
      rst1_mask_i = 8'h04;
      apply(8'h04);
      chk(out1_o, 1'b0, "R4 same compare keeps out1 low");
      set1_mask_i = 8'h01;
      rst1_mask_i = 8'h02;

      // R8: compare floor per prescaler
      cmp_vals_i[15:0] = 16'h005F; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R8 psc0 0x5F");
      cmp_vals_i[15:0] = 16'h0060; apply(8'h00);
      chk(cfg_err_o, 1'b0, "R8 psc0 0x60");
      psc_i = 3'd1;
      cmp_vals_i[15:0] = 16'h002F; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R8 psc1 0x2F");
      cmp_vals_i[15:0] = 16'h0030; apply(8'h00);
      chk(cfg_err_o, 1'b0, "R8 psc1 0x30");
      psc_i = 3'd2;
      cmp_vals_i[15:0] = 16'h0017; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R8 psc2 0x17");
      cmp_vals_i[15:0] = 16'h0018; apply(8'h00);
      chk(cfg_err_o, 1'b0, "R8 psc2 0x18");
      psc_i = 3'd0;
      cmp_vals_i[15:0] = 16'h0100;

      // R9: null-duty exception
      set1_mask_i = 8'h01; rst1_mask_i = 8'h02;
      set2_mask_i = 8'h01; rst2_mask_i = 8'h08;
      cmp_local_i = 2'b11;
      cmp_vals_i[15:0]  = 16'h0000;
      cmp_vals_i[47:32] = 16'h0000;
      apply(8'h00);
      chk(cfg_err_o, 1'b0, "R9 legal zero compares");
      apply(8'h0B);
      chk(out1_o, 1'b0, "R9 skipped pulse out1");
      chk(out2_o, 1'b0, "R9 skipped pulse out2");
      cmp_local_i = 2'b01; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R9 compare 3 not private");
      cmp_local_i = 2'b11;
      cmp_vals_i[31:16] = 16'h0000; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R9 zero compare 2");
      cmp_vals_i[31:16] = 16'h0100;
      cmp_vals_i[47:32] = 16'h0100; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R9 only compare 1 zero");
      cmp_vals_i[47:32] = 16'h0000;
      set2_mask_i = 8'h03; apply(8'h00);
      chk(cfg_err_o, 1'b1, "R9 set mask not period only");
      set2_mask_i = 8'h01; apply(8'h00);
      chk(cfg_err_o, 1'b0, "R9 legal again");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule